// File: doc/BRIEF.md
# Falling-Edge Watchdog Timer with Selectable Period

This block watches a line that a host processor must pulse from high to low at regular intervals. The same line also serves as the chip-select of a serial port. Each high-to-low transition counts as a kick and restarts an internal tick counter. If the counter reaches the selected period with no kick, the block raises a one-cycle timeout strobe. It then reloads and starts counting again. A downstream reset generator turns that strobe into a system reset pulse.

Two bits from a status register choose the period. Three codes pick a short, middle or long tick count, each set by a parameter. The fourth code switches the watchdog off. A kick is recognised only on a falling edge, so a line that stays high and a line that stays low both lead to a timeout. A separate active-high system reset input holds the counter at zero for as long as it is asserted. Counting resumes when it is released.

Top module: `wdog_edge_timer`

## Requirements
- R1: A high-to-low transition on `wdi_i` clears the count. The clear takes effect SYNC_STAGES+1 clock edges after the first edge that samples the low level, and the next timeout comes one full period after that clear.
- R2: With `wdi_i` held high and the watchdog enabled, `timeout_o` rises exactly one period of clock edges after the count was last cleared. It stays high for exactly one cycle.
- R3: With `wdi_i` held low, timeouts occur in the same way as in R2. A low-to-high transition on `wdi_i` does not clear the count.
- R4: Select code 2'b00 gives SHORT_TICKS edges per period (16 by default), 2'b01 gives MID_TICKS (48), and 2'b10 gives LONG_TICKS (128).
- R5: Select code 2'b11 disables the watchdog: `timeout_o` stays low and the count is held at zero. On a later change to an enabled code, counting starts from zero.
- R6: Any change of `period_sel_i` clears the count on the first edge that sees the new value. The next timeout then comes one new period after the edge that follows.
- R7: While `sys_rst_i` is high, the count is held at zero and `timeout_o` stays low. After release, the first timeout comes one period of edges later, counting the first edge after release.
- R8: After a timeout, the count reloads with no gap, so with no kicks a stalled line gives a strobe every period.
- R9: While `rst_ni` is low, `timeout_o` is low. After release with an enabled code, the first edge clears the count, and the first timeout follows one period after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Tick clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sys_rst_i | input | 1 | Synchronous hold of the counter, active high |
| wdi_i | input | 1 | Watchdog kick line, asynchronous (shared chip-select) |
| period_sel_i | input | 2 | Period code from the status register: 00 short, 01 middle, 10 long, 11 off |
| timeout_o | output | 1 | One-cycle strobe when the period expires with no kick |

## Verification
The bench measures the exact edge on which each timeout falls after a restart. A counter off by one would move the strobe a cycle early or late. It checks that a line stuck low times out just like a line stuck high, and that a rising edge gives no restart. A detector that acted on both edges would hide that fault. It switches the period in the middle of a long count; without a restart, the block would fire at once, because the old count already exceeds the short limit. It also holds the system reset and the off code for long stretches, where a design that ignored them would still emit strobes.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    WD_SHORT = 2'b00,
    WD_MID   = 2'b01,
    WD_LONG  = 2'b10,
    WD_OFF   = 2'b11
  } wd_sel_e;
endpackage

// File: rtl/wdog_in_sync.sv
module wdog_in_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wdi_i,
  output logic kick_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  // idle level of a deselected chip-select is high
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[g] <= 1'b1;
      else if (g == 0) sync_q[g] <= wdi_i;
      else sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else prev_q <= sync_q[STAGES-1];
  end

  assign kick_o = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/wdog_period_sel.sv
module wdog_period_sel
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned SHORT_TICKS = 16,
  parameter int unsigned MID_TICKS   = 48,
  parameter int unsigned LONG_TICKS  = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       sel_i,
  output logic [CNT_W-1:0] limit_o,
  output logic             en_o,
  output logic             restart_o
);
  wd_sel_e sel_q;
  wd_sel_e sel_w;

  assign sel_w = wd_sel_e'(sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= WD_OFF;
    else sel_q <= sel_w;
  end

  assign restart_o = (sel_q != sel_w);

  always_comb begin
    en_o    = 1'b1;
    limit_o = CNT_W'(SHORT_TICKS);
    unique case (sel_w)
      WD_SHORT: limit_o = CNT_W'(SHORT_TICKS);
      WD_MID:   limit_o = CNT_W'(MID_TICKS);
      WD_LONG:  limit_o = CNT_W'(LONG_TICKS);
      WD_OFF:   en_o    = 1'b0;
      default:  en_o    = 1'b0;
    endcase
  end
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             exp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else begin
      exp_q <= 1'b0;
      if (clr_i || !en_i) begin
        cnt_q <= '0;
      end else if (cnt_q >= limit_i - 1'b1) begin
        // >= also covers a count left above a newly shortened limit
        cnt_q <= '0;
        exp_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign cnt_o    = cnt_q;
  assign expire_o = exp_q;
endmodule

// File: rtl/wdog_edge_timer.sv
module wdog_edge_timer #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SHORT_TICKS = 16,
  parameter int unsigned MID_TICKS   = 48,
  parameter int unsigned LONG_TICKS  = 128
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sys_rst_i,
  input  logic       wdi_i,
  input  logic [1:0] period_sel_i,
  output logic       timeout_o
);
  localparam int unsigned CNT_W = $clog2(LONG_TICKS + 1);

  logic             kick_w;
  logic             restart_w;
  logic             en_w;
  logic [CNT_W-1:0] limit_w;
  logic [CNT_W-1:0] cnt_w;

  wdog_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wdi_i  (wdi_i),
    .kick_o (kick_w)
  );

  wdog_period_sel #(
    .CNT_W       (CNT_W),
    .SHORT_TICKS (SHORT_TICKS),
    .MID_TICKS   (MID_TICKS),
    .LONG_TICKS  (LONG_TICKS)
  ) u_sel (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (period_sel_i),
    .limit_o   (limit_w),
    .en_o      (en_w),
    .restart_o (restart_w)
  );

  wdog_count #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (sys_rst_i | kick_w | restart_w),
    .en_i     (en_w),
    .limit_i  (limit_w),
    .cnt_o    (cnt_w),
    .expire_o (timeout_o)
  );
endmodule

// File: rtl/wdog_edge_timer_chk.sv
module wdog_edge_timer_chk #(
  parameter int unsigned LONG_TICKS = 128,
  parameter int unsigned CNT_W      = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sys_rst_i,
  input logic [1:0]       period_sel_i,
  input logic             kick_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             timeout_o
);
  // R2
  single_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !timeout_o);

  // R1
  kick_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_i |=> (!timeout_o && cnt_i == '0));

  // R5
  off_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_sel_i == 2'b11) |=> !timeout_o);

  // R7
  hold_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_i |=> (!timeout_o && cnt_i == '0));

  // R6
  sel_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_sel_i != $past(period_sel_i)) |=> !timeout_o);

  // R4
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i < CNT_W'(LONG_TICKS));
endmodule

bind wdog_edge_timer wdog_edge_timer_chk #(
  .LONG_TICKS (LONG_TICKS),
  .CNT_W      (CNT_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sys_rst_i    (sys_rst_i),
  .period_sel_i (period_sel_i),
  .kick_i       (kick_w),
  .cnt_i        (cnt_w),
  .timeout_o    (timeout_o)
);

// File: tb/wdog_edge_timer_test.sv
module wdog_edge_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sys_rst = 1'b1;
  logic       wdi = 1'b1;
  logic [1:0] sel = 2'b00;
  logic       tmo;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  wdog_edge_timer uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .sys_rst_i    (sys_rst),
    .wdi_i        (wdi),
    .period_sel_i (sel),
    .timeout_o    (tmo)
  );

  typedef struct packed {
    logic [1:0]  sel;
    logic        lvl;
    int unsigned gap;
    int unsigned n;
    int unsigned exp;
  } vec_t;

  // sel, idle level, kick spacing (0 none), edges, expected strobes
  localparam vec_t VECS [9] = '{
    '{2'b00, 1'b1, 0,   100, 6},  // R2 R8 short
    '{2'b01, 1'b1, 0,   100, 2},  // R4 middle
    '{2'b10, 1'b1, 0,   300, 2},  // R4 long
    '{2'b11, 1'b1, 0,   300, 0},  // R5 off
    '{2'b00, 1'b0, 0,   100, 6},  // R3 stuck low
    '{2'b00, 1'b1, 8,   200, 0},  // R1 kicked
    '{2'b01, 1'b1, 30,  200, 0},  // R1 kicked
    '{2'b10, 1'b1, 100, 400, 0},  // R1 kicked
    '{2'b11, 1'b0, 0,   150, 0}   // R5 off, low
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic restart(input logic [1:0] s, input logic lvl);
    sys_rst = 1'b1;
    sel = s;
    wdi = lvl;
    for (int i = 0; i < 5; i++) step();
    sys_rst = 1'b0;
  endtask

  task automatic run(input int k, output int cnt);
    cnt = 0;
    for (int i = 0; i < k; i++) begin
      step();
      if (tmo) cnt++;
    end
  endtask

  initial begin
    #1_200_000;
    n_bad++;
    $display("FAIL watchdog: got 0 expected 1 (run finished)");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int c;
    @(negedge clk);
    step();
    check(int'(tmo), 0, "R9 in reset");
    rst_n = 1'b1;
    step();

    foreach (VECS[v]) begin
      restart(VECS[v].sel, VECS[v].gap != 0 ? 1'b1 : VECS[v].lvl);
      c = 0;
      for (int i = 0; i < int'(VECS[v].n); i++) begin
        if (VECS[v].gap != 0)
          wdi = ((i % int'(VECS[v].gap)) < int'(VECS[v].gap) / 2) ? 1'b0 : 1'b1;
        step();
        if (tmo) c++;
      end
      check(c, int'(VECS[v].exp), $sformatf("R4 vector %0d", v));
    end

    // R2 exact edge and one-cycle width, R8 reload
    restart(2'b00, 1'b1);
    run(15, c);
    check(c, 0, "R2 early");
    step();
    check(int'(tmo), 1, "R2 on 16th edge");
    step();
    check(int'(tmo), 0, "R2 strobe width");
    run(14, c);
    check(c, 0, "R8 gap");
    step();
    check(int'(tmo), 1, "R8 second strobe");

    // R1 kick mid-count defers timeout
    restart(2'b00, 1'b1);
    run(12, c);
    wdi = 1'b0;
    run(14, c);
    check(c, 0, "R1 deferred");
    run(10, c);
    check(c, 1, "R1 after kick");

    // R3 rising edge is not a kick
    restart(2'b00, 1'b0);
    run(12, c);
    wdi = 1'b1;
    run(3, c);
    check(c, 0, "R3 before expiry");
    step();
    check(int'(tmo), 1, "R3 rise ignored");

    // R6 period change restarts count
    restart(2'b01, 1'b1);
    run(40, c);
    check(c, 0, "R6 before change");
    sel = 2'b00;
    run(16, c);
    check(c, 0, "R6 restarted");
    step();
    check(int'(tmo), 1, "R6 new period");

    // R5 off then re-enable
    restart(2'b00, 1'b1);
    run(10, c);
    sel = 2'b11;
    run(300, c);
    check(c, 0, "R5 off");
    sel = 2'b00;
    run(16, c);
    check(c, 0, "R5 re-enable early");
    step();
    check(int'(tmo), 1, "R5 re-enable");

    // R7 system reset hold
    restart(2'b00, 1'b1);
    run(10, c);
    sys_rst = 1'b1;
    run(40, c);
    check(c, 0, "R7 held");
    sys_rst = 1'b0;
    run(15, c);
    check(c, 0, "R7 after release");
    step();
    check(int'(tmo), 1, "R7 first strobe");

    // R9 async reset mid-count
    restart(2'b00, 1'b1);
    run(15, c);
    rst_n = 1'b0;
    #1;
    check(int'(tmo), 0, "R9 async");
    step();
    rst_n = 1'b1;
    run(16, c);
    check(c, 0, "R9 after release");
    step();
    check(int'(tmo), 1, "R9 first strobe");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule